// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the register side of a four-channel DMA controller of the classic single-port kind. The host reaches it through an 8-bit I/O port with a 4-bit offset. Each channel keeps a 16-bit start address and a 16-bit transfer count. Both travel over the 8-bit port one byte at a time. A single pointer flip-flop, shared by all channels, decides whether an access goes to the low byte or the high byte. The count is held as the number of transfers minus one.

The block also holds:
- a per-channel mask bit, set or cleared singly or all at once;
- a per-channel mode field;
- a command byte;
- a latched terminal-count status.

Several write-only offsets act as commands: clear the pointer, clear all masks, and master clear. The transfer engine sits beside this block. It receives the base values with a one-cycle load strobe whenever the host writes a base byte. It returns its live current address and count, and the host reads these back through the same byte-steered offsets. The engine also reports terminal-count pulses, which the status read collects and clears.

Top module: `dma_chan_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every base address and base count clears to 0x0000, all four mask bits set, and the mode fields, command byte, terminal-count flags and byte pointer clear (low byte selected).
- R2: A write to offset 2n (n = 0..3) stores `io_wdata` into the low byte of channel n's base address if the pointer is low, or into the high byte if it is high. `ld_addr[n]` is high for exactly the one cycle after that write.
- R3: A write to offset 2n+1 does the same for channel n's base count, with `ld_cnt[n]` as the strobe. The count is held in minus-one form: 0x0000 means one transfer and 0xFFFF means 65536.
- R4: Every read or write to offsets 0x0..0x7 inverts the byte pointer, whichever channel the access targets. A write of any value to offset 0xC forces the pointer low.
- R5: A read of offset 2n returns one byte of channel n's live engine address from `eng_cur_addr`; a read of offset 2n+1 returns one byte of its live count from `eng_cur_cnt`. The pointer picks the byte: low when the pointer is low, high when it is high.
- R6: A write to offset 0xA sets mask bit `io_wdata[1:0]` to `io_wdata[2]`: 1 masks the channel, 0 unmasks it. The other mask bits keep their values.
- R7: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads all four mask bits from `io_wdata[3:0]`.
- R8: A write to offset 0xB stores `io_wdata[7:2]` as the mode field of channel `io_wdata[1:0]`. It appears on `chan_mode[6n+5:6n]` with the same bit order: direction in bits 1:0, auto-initialize in bit 2, address decrement in bit 3, and mode in bits 5:4.
- R9: A write to offset 0x8 stores the command byte on `cmd_word`. A read of offset 0x8 returns the flags latched from `eng_tc` in bits 3:0, with bits 7:4 zero, and then clears those flags. A pulse arriving in the same cycle as that read stays latched for the next read.
- R10: A write to offset 0xD (master clear) acts like reset on the pointer, masks, mode fields, command byte and flags. It leaves the base registers unchanged and overrides an `eng_tc` pulse in the same cycle.
- R11: Reads of offsets 0x9 to 0xF return 0x00. A write to offset 0x9 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational, valid while `io_rd` is high) |
| eng_cur_addr | input | 64 | Engine current address, channel n at bits 16n+15:16n |
| eng_cur_cnt | input | 64 | Engine current count (minus-one form), channel n at bits 16n+15:16n |
| eng_tc | input | 4 | Terminal-count pulses from the engine, one per channel |
| base_addr | output | 64 | Base address, channel n at bits 16n+15:16n |
| base_cnt | output | 64 | Base count, channel n at bits 16n+15:16n |
| ld_addr | output | 4 | One-cycle strobe: engine loads its current address from `base_addr` |
| ld_cnt | output | 4 | One-cycle strobe: engine loads its current count from `base_cnt` |
| chan_mask | output | 4 | Mask bits, 1 disables the channel |
| chan_mode | output | 24 | Mode fields, 6 bits per channel |
| cmd_word | output | 8 | Command byte |
| ptr_hi | output | 1 | Byte pointer, 1 selects the high byte |

## Verification
Two functions can fall in the same cycle. The first is a terminal-count pulse from the engine arriving in the very cycle the host reads and clears the status. The second is a master clear arriving in the same cycle as such a pulse. Directed steps drive `eng_tc` together with a status read, and separately together with a master-clear write. The following status read must show the new flag in the first case and nothing in the second. The random phase mixes pulses with every kind of access. The shared pointer is judged by letting accesses to one channel's offsets decide the byte order that the next access to a different channel receives.

// File: rtl/dma_regs_pkg.sv
// Package: shared constants for the DMA programming register file.
// Offsets that have a fixed meaning are kept here so that decode and
// checker agree. Channel offsets are 0x0..0x7 (address at even, count at odd).
package dma_regs_pkg;
    localparam int NUM_CH    = 4;
    localparam int CH_SEL_W  = $clog2(NUM_CH);
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int MODE_W    = 6;
    localparam int OFS_W     = 4;

    localparam logic [OFS_W-1:0] OFS_CMD     = 4'h8;
    localparam logic [OFS_W-1:0] OFS_REQ     = 4'h9;
    localparam logic [OFS_W-1:0] OFS_MASK1   = 4'hA;
    localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
    localparam logic [OFS_W-1:0] OFS_PTRCLR  = 4'hC;
    localparam logic [OFS_W-1:0] OFS_MCLR    = 4'hD;
    localparam logic [OFS_W-1:0] OFS_MASKCLR = 4'hE;
    localparam logic [OFS_W-1:0] OFS_MASKALL = 4'hF;
endpackage

// File: rtl/dma_byte_ptr.sv
// Module: dma_byte_ptr
// Shared low/high byte pointer. Toggles on each channel-register access.
// Clear has priority over toggle. Assumes at most one access per cycle.
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic clear,
    output logic hi
);
    // Pointer state: reset/clear to low byte, otherwise flip per access.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hi <= 1'b0;
        end else if (toggle) begin
            hi <= ~hi;
        end
    end
endmodule

// File: rtl/dma_chan_bank.sv
// Module: dma_chan_bank
// Per-channel base address and base count registers, each loaded one
// byte at a time. The byte is chosen by the shared pointer. Each byte write
// raises the matching load strobe for one cycle so the engine copies the
// base value into its current copy. Assumes WORD_W is two bytes.
module dma_chan_bank
    import dma_regs_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int B_W    = BYTE_W,
    parameter int SEL_W  = CH_SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 sel_cnt,
    input  logic [SEL_W-1:0]     sel_ch,
    input  logic                 hi,
    input  logic [B_W-1:0]       wdata,
    output logic [N_CH*2*B_W-1:0] base_addr,
    output logic [N_CH*2*B_W-1:0] base_cnt,
    output logic [N_CH-1:0]      ld_addr,
    output logic [N_CH-1:0]      ld_cnt
);
    localparam int W_W = 2 * B_W;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic hit;
        assign hit = wr_en && (sel_ch == SEL_W'(ch));

        // Base address bytes and their load strobe for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_addr[ch*W_W +: W_W] <= '0;
                ld_addr[ch]              <= 1'b0;
            end else begin
                ld_addr[ch] <= hit && !sel_cnt;
                if (hit && !sel_cnt) begin
                    if (hi) base_addr[ch*W_W + B_W +: B_W] <= wdata;
                    else    base_addr[ch*W_W       +: B_W] <= wdata;
                end
            end
        end

        // Base count bytes (minus-one form) and their load strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_cnt[ch*W_W +: W_W] <= '0;
                ld_cnt[ch]              <= 1'b0;
            end else begin
                ld_cnt[ch] <= hit && sel_cnt;
                if (hit && sel_cnt) begin
                    if (hi) base_cnt[ch*W_W + B_W +: B_W] <= wdata;
                    else    base_cnt[ch*W_W       +: B_W] <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/dma_ctl_regs.sv
// Module: dma_ctl_regs
// Control state: mask bits, per-channel mode fields, command byte and
// latched terminal-count flags. Master clear resets all of it (masks set).
// A status read hands back the old flags and keeps only pulses of the same cycle.
module dma_ctl_regs
    import dma_regs_pkg::*;
#(
    parameter int N_CH  = NUM_CH,
    parameter int B_W   = BYTE_W,
    parameter int M_W   = MODE_W,
    parameter int SEL_W = CH_SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFS_W-1:0]    ofs,
    input  logic [B_W-1:0]      wdata,
    input  logic                mclr,
    input  logic                st_rd,
    input  logic [N_CH-1:0]     eng_tc,
    output logic [N_CH-1:0]     mask,
    output logic [N_CH*M_W-1:0] mode,
    output logic [B_W-1:0]      cmd,
    output logic [N_CH-1:0]     tc_flags
);
    logic [SEL_W-1:0] wsel;
    assign wsel = wdata[SEL_W-1:0];

    // Mask bits: single-channel, clear-all and load-all writes.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            mask <= '1;
        end else if (wr_en) begin
            case (ofs)
                OFS_MASK1:   mask[wsel] <= wdata[SEL_W];
                OFS_MASKCLR: mask       <= '0;
                OFS_MASKALL: mask       <= wdata[N_CH-1:0];
                default:     mask       <= mask;
            endcase
        end
    end

    // Mode field per channel, written with the channel number in the data.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n || mclr) begin
                mode[ch*M_W +: M_W] <= '0;
            end else if (wr_en && ofs == OFS_MODE && wsel == SEL_W'(ch)) begin
                mode[ch*M_W +: M_W] <= wdata[B_W-1 -: M_W];
            end
        end
    end

    // Command byte.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            cmd <= '0;
        end else if (wr_en && ofs == OFS_CMD) begin
            cmd <= wdata;
        end
    end

    // Terminal-count flags: accumulate pulses, clear on status read.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            tc_flags <= '0;
        end else if (st_rd) begin
            tc_flags <= eng_tc;
        end else begin
            tc_flags <= tc_flags | eng_tc;
        end
    end
endmodule

// File: rtl/dma_chan_regfile.sv
// Module: dma_chan_regfile (top)
// Host-side register file of a four-channel DMA controller. It decodes
// the 4-bit offset, steers 16-bit registers through the shared byte pointer
// and muxes the combinational read data. Assumes io_wr and io_rd are
// single-cycle strobes and are never high together.
module dma_chan_regfile
    import dma_regs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [OFS_W-1:0]         io_addr,
    input  logic [BYTE_W-1:0]        io_wdata,
    output logic [BYTE_W-1:0]        io_rdata,
    input  logic [NUM_CH*WORD_W-1:0] eng_cur_addr,
    input  logic [NUM_CH*WORD_W-1:0] eng_cur_cnt,
    input  logic [NUM_CH-1:0]        eng_tc,
    output logic [NUM_CH*WORD_W-1:0] base_addr,
    output logic [NUM_CH*WORD_W-1:0] base_cnt,
    output logic [NUM_CH-1:0]        ld_addr,
    output logic [NUM_CH-1:0]        ld_cnt,
    output logic [NUM_CH-1:0]        chan_mask,
    output logic [NUM_CH*MODE_W-1:0] chan_mode,
    output logic [BYTE_W-1:0]        cmd_word,
    output logic                     ptr_hi
);
    logic                chan_acc;
    logic                chan_wr;
    logic                ptr_clr;
    logic                mclr;
    logic                st_rd;
    logic [CH_SEL_W-1:0] ch_sel;
    logic [NUM_CH-1:0]   tc_flags;
    logic [WORD_W-1:0]   rd_word;

    // Offset decode: channel window is offsets with the top bit clear.
    assign chan_acc = (io_wr || io_rd) && !io_addr[OFS_W-1];
    assign chan_wr  = io_wr && !io_addr[OFS_W-1];
    assign ch_sel   = io_addr[CH_SEL_W:1];
    assign mclr     = io_wr && (io_addr == OFS_MCLR);
    assign ptr_clr  = mclr || (io_wr && (io_addr == OFS_PTRCLR));
    assign st_rd    = io_rd && (io_addr == OFS_CMD);

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (chan_acc),
        .clear  (ptr_clr),
        .hi     (ptr_hi)
    );

    dma_chan_bank #(
        .N_CH  (NUM_CH),
        .B_W   (BYTE_W),
        .SEL_W (CH_SEL_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (chan_wr),
        .sel_cnt   (io_addr[0]),
        .sel_ch    (ch_sel),
        .hi        (ptr_hi),
        .wdata     (io_wdata),
        .base_addr (base_addr),
        .base_cnt  (base_cnt),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt)
    );

    dma_ctl_regs #(
        .N_CH  (NUM_CH),
        .B_W   (BYTE_W),
        .M_W   (MODE_W),
        .SEL_W (CH_SEL_W)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (io_wr),
        .ofs      (io_addr),
        .wdata    (io_wdata),
        .mclr     (mclr),
        .st_rd    (st_rd),
        .eng_tc   (eng_tc),
        .mask     (chan_mask),
        .mode     (chan_mode),
        .cmd      (cmd_word),
        .tc_flags (tc_flags)
    );

    // Pick the live engine word addressed by the channel offset.
    always_comb begin
        if (io_addr[0]) rd_word = eng_cur_cnt[ch_sel*WORD_W +: WORD_W];
        else            rd_word = eng_cur_addr[ch_sel*WORD_W +: WORD_W];
    end

    // Read mux: pointer-selected byte, status flags, zero elsewhere.
    always_comb begin
        io_rdata = '0;
        if (!io_addr[OFS_W-1]) begin
            io_rdata = ptr_hi ? rd_word[WORD_W-1 -: BYTE_W] : rd_word[BYTE_W-1:0];
        end else if (io_addr == OFS_CMD) begin
            io_rdata = {{(BYTE_W-NUM_CH){1'b0}}, tc_flags};
        end
    end
endmodule

// File: rtl/dma_chan_regfile_chk.sv
// Module: dma_chan_regfile_chk
// Protocol checker bound to the top module. Watches port-level behaviour
// of the pointer, the masks, master clear, the load strobes and the status read.
module dma_chan_regfile_chk
    import dma_regs_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     io_wr,
    input logic                     io_rd,
    input logic [OFS_W-1:0]         io_addr,
    input logic [BYTE_W-1:0]        io_rdata,
    input logic [NUM_CH-1:0]        ld_addr,
    input logic [NUM_CH-1:0]        ld_cnt,
    input logic [NUM_CH-1:0]        chan_mask,
    input logic [BYTE_W-1:0]        cmd_word,
    input logic                     ptr_hi
);
    // R4: a channel-window access inverts the pointer.
    a_r4_ptr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && !io_addr[OFS_W-1]) |=> (ptr_hi == !$past(ptr_hi)));

    // R4: a pointer-clear write leaves the pointer low.
    a_r4_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_PTRCLR) |=> !ptr_hi);

    // R10: master clear sets every mask and clears the command and pointer.
    a_r10_master_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_MCLR) |=> (chan_mask == '1 && cmd_word == '0 && !ptr_hi));

    // R7: clear-mask write empties the mask.
    a_r7_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFS_MASKCLR) |=> (chan_mask == '0));

    // R6: masks move only on mask-related writes.
    a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && (io_addr == OFS_MASK1 || io_addr == OFS_MASKCLR ||
                    io_addr == OFS_MASKALL || io_addr == OFS_MCLR)) |=> $stable(chan_mask));

    // R2: address load strobe is one-hot and follows an even channel write.
    a_r2_ld_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_addr != '0) |-> ($onehot0(ld_addr) && $past(io_wr && !io_addr[OFS_W-1] && !io_addr[0])));

    // R3: count load strobe is one-hot and follows an odd channel write.
    a_r3_ld_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cnt != '0) |-> ($onehot0(ld_cnt) && $past(io_wr && !io_addr[OFS_W-1] && io_addr[0])));

    // R9: status read has an empty upper nibble.
    a_r9_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == OFS_CMD) |-> (io_rdata[BYTE_W-1:NUM_CH] == '0));

    // R11: reads above the status offset return zero.
    a_r11_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr[OFS_W-1] && io_addr != OFS_CMD) |-> (io_rdata == '0));
endmodule

bind dma_chan_regfile dma_chan_regfile_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_addr   (io_addr),
    .io_rdata  (io_rdata),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .chan_mask (chan_mask),
    .cmd_word  (cmd_word),
    .ptr_hi    (ptr_hi)
);

// File: tb/dma_chan_regfile_tb_top.sv
// Bench: directed corner cases plus seeded random accesses, checked
// against a reference model kept in bench variables.
module dma_chan_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_wr, io_rd;
    logic [3:0]  io_addr;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic [63:0] eng_cur_addr, eng_cur_cnt;
    logic [3:0]  eng_tc;
    logic [63:0] base_addr, base_cnt;
    logic [3:0]  ld_addr, ld_cnt, chan_mask;
    logic [23:0] chan_mode;
    logic [7:0]  cmd_word;
    logic        ptr_hi;

    always #10 clk = ~clk;

    dma_chan_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .eng_cur_addr(eng_cur_addr), .eng_cur_cnt(eng_cur_cnt), .eng_tc(eng_tc),
        .base_addr(base_addr), .base_cnt(base_cnt), .ld_addr(ld_addr),
        .ld_cnt(ld_cnt), .chan_mask(chan_mask), .chan_mode(chan_mode),
        .cmd_word(cmd_word), .ptr_hi(ptr_hi)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [5:0]  m_mode [4];
    logic [3:0]  m_mask, m_tc, m_lda, m_ldc;
    logic [7:0]  m_cmd;
    logic        m_ptr;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 4; i++) begin
            m_addr[i] = '0; m_cnt[i] = '0; m_mode[i] = '0;
        end
        m_mask = 4'hF; m_tc = '0; m_cmd = '0; m_ptr = 1'b0;
        m_lda = '0; m_ldc = '0;
    endfunction

    // Expected read data from the model before the access takes effect.
    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [15:0] w;
        if (!a[3]) begin
            w = a[0] ? eng_cur_cnt[a[2:1]*16 +: 16] : eng_cur_addr[a[2:1]*16 +: 16];
            return m_ptr ? w[15:8] : w[7:0];
        end
        if (a == 4'h8) return {4'b0, m_tc};
        return 8'h00;
    endfunction

    // Model update for one access.
    function automatic void model_step(input logic wr, input logic [3:0] a,
                                       input logic [7:0] d, input logic [3:0] tc);
        int ch;
        m_lda = '0; m_ldc = '0;
        ch = int'(a[2:1]);
        if (!a[3]) begin
            if (wr) begin
                if (a[0]) begin
                    if (m_ptr) m_cnt[ch][15:8] = d; else m_cnt[ch][7:0] = d;
                    m_ldc[ch] = 1'b1;
                end else begin
                    if (m_ptr) m_addr[ch][15:8] = d; else m_addr[ch][7:0] = d;
                    m_lda[ch] = 1'b1;
                end
            end
            m_ptr = !m_ptr;
        end
        if (!wr && a == 4'h8) m_tc = tc; else m_tc = m_tc | tc;
        if (wr) begin
            case (a)
                4'h8: m_cmd = d;
                4'hA: m_mask[d[1:0]] = d[2];
                4'hB: m_mode[d[1:0]] = d[7:2];
                4'hC: m_ptr = 1'b0;
                4'hD: begin
                    m_ptr = 1'b0; m_cmd = '0; m_mask = 4'hF; m_tc = '0;
                    for (int i = 0; i < 4; i++) m_mode[i] = '0;
                end
                4'hE: m_mask = '0;
                4'hF: m_mask = d[3:0];
                default: ;
            endcase
        end
    endfunction

    task automatic check_state(input string tag);
        for (int i = 0; i < 4; i++) begin
            chk({tag, " R2 base_addr"}, base_addr[i*16 +: 16], m_addr[i]);
            chk({tag, " R3 base_cnt"},  base_cnt[i*16 +: 16],  m_cnt[i]);
            chk({tag, " R8 chan_mode"}, chan_mode[i*6 +: 6],   m_mode[i]);
        end
        chk({tag, " R6 chan_mask"}, chan_mask, m_mask);
        chk({tag, " R9 cmd_word"},  cmd_word,  m_cmd);
        chk({tag, " R4 ptr_hi"},    ptr_hi,    m_ptr);
    endtask

    // One host access; read data sampled mid-cycle, state after the edge.
    task automatic op(input logic wr, input logic [3:0] a, input logic [7:0] d,
                      input logic [3:0] tc, input string tag);
        logic [7:0] er;
        @(negedge clk);
        io_wr = wr; io_rd = !wr; io_addr = a; io_wdata = d; eng_tc = tc;
        er = exp_rd(a);
        #5;
        if (!wr) chk({tag, " R5/R9/R11 io_rdata"}, io_rdata, er);
        model_step(wr, a, d, tc);
        @(negedge clk);
        chk({tag, " R2 ld_addr"}, ld_addr, m_lda);
        chk({tag, " R3 ld_cnt"},  ld_cnt,  m_ldc);
        io_wr = 1'b0; io_rd = 1'b0; eng_tc = '0;
        check_state(tag);
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        rst_n = 1'b0; io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
        eng_tc = 0; eng_cur_addr = '0; eng_cur_cnt = '0;
        model_reset();
        repeat (3) @(negedge clk);
        check_state("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 after release");

        // R2: channel 2 address, low then high byte.
        op(1, 4'h4, 8'h34, 0, "R2 ch2 lo");
        op(1, 4'h4, 8'h12, 0, "R2 ch2 hi");
        // R3: channel 1 count of one transfer, channel 3 count of 65536.
        op(1, 4'h3, 8'h00, 0, "R3 ch1 lo");
        op(1, 4'h3, 8'h00, 0, "R3 ch1 hi");
        op(1, 4'h7, 8'hFF, 0, "R3 ch3 lo");
        op(1, 4'h7, 8'hFF, 0, "R3 ch3 hi");
        // R4: pointer shared; second byte lands in channel 1 high address byte.
        op(1, 4'h0, 8'hAA, 0, "R4 ch0 lo");
        op(1, 4'h2, 8'hBB, 0, "R4 ch1 hi shared");
        op(1, 4'h0, 8'h11, 0, "R4 set hi");
        op(1, 4'hC, 8'h5A, 0, "R4 clear ptr");
        // R5: read live engine values.
        eng_cur_addr[48 +: 16] = 16'hBEEF;
        eng_cur_cnt[48 +: 16]  = 16'hFFFF;
        op(0, 4'h6, 8'h00, 0, "R5 ch3 addr lo");
        op(0, 4'h6, 8'h00, 0, "R5 ch3 addr hi");
        op(0, 4'h7, 8'h00, 0, "R5 ch3 cnt lo done");
        op(0, 4'h7, 8'h00, 0, "R5 ch3 cnt hi done");
        // R6 / R7 masks.
        op(1, 4'hE, 8'h00, 0, "R7 clear masks");
        op(1, 4'hA, 8'h06, 0, "R6 mask ch2");
        op(1, 4'hA, 8'h02, 0, "R6 unmask ch2");
        op(1, 4'hF, 8'h0A, 0, "R7 load masks");
        // R8 modes using the common encodings.
        op(1, 4'hB, 8'h44, 0, "R8 ch0 mode");
        op(1, 4'hB, 8'h49, 0, "R8 ch1 mode");
        op(1, 4'hB, 8'hD2, 0, "R8 ch2 mode");
        // R9 command and status with a same-cycle pulse.
        op(1, 4'h8, 8'hC3, 0, "R9 command");
        op(1, 4'h9, 8'h77, 4'b0010, "R11 req write ignored / R9 tc latch");
        op(0, 4'h8, 8'h00, 4'b0100, "R9 status read same-cycle tc");
        op(0, 4'h8, 8'h00, 0, "R9 status keeps new tc");
        op(0, 4'h8, 8'h00, 0, "R9 status cleared");
        // R11 temp and unused reads.
        op(0, 4'hD, 8'h00, 0, "R11 temp read");
        op(0, 4'hB, 8'h00, 0, "R11 unused read");
        // R10 master clear against a pulse, with the pointer high.
        op(1, 4'h1, 8'h99, 0, "R10 ptr hi prep");
        op(1, 4'hD, 8'h00, 4'b1001, "R10 master clear");
        op(0, 4'h8, 8'h00, 0, "R10 status after clear");

        // Random phase.
        for (int k = 0; k < 600; k++) begin
            logic [3:0] a;
            logic       w;
            a = 4'($urandom_range(0, 15));
            w = 1'($urandom_range(0, 1));
            if (a == 4'hD && $urandom_range(0, 3) != 0) a = 4'h5;
            eng_cur_addr = {$urandom, $urandom};
            eng_cur_cnt  = {$urandom, $urandom};
            op(w, a, 8'($urandom), ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0,
               "random");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule